// File: doc/BRIEF.md
# Subclock Sleep-State Controller

This block decides when a small microcontroller drops from its low-speed running state into a clock-gated sleep state, and when it comes back. The CPU signals a sleep attempt with a one-cycle strobe. The attempt succeeds only if three mode-select bits hold one exact pattern. While asleep, the block stops the CPU, freezes the I/O port drivers, and gates off every peripheral clock group except the A/D converter and the watchdog. CPU registers, RAM and peripheral registers are left untouched, so their contents survive the sleep period.

Two things end the sleep state. The first is an interrupt request whose enable bit is set while the global mask is clear. That request is resynchronised to the slow subclock through two stages, and then the block emits a single-cycle wake strobe that starts interrupt exception handling. The second is a low level on the reset pin, which returns the block asynchronously to the running state. The subclock reaches the block as a one-cycle tick that is sampled on the system clock.

States: `ST_RUN` (low-speed running), `ST_DOZE` (asleep), `ST_RESUME` (one cycle, wake strobe high). Transitions:
- `RUN->DOZE`: sleep strobe with a valid mode.
- `DOZE->RESUME`: synchronised wake.
- `RESUME->RUN`: unconditional.
- any state `->RUN`: reset pin low.

Top module: `sleep_ctrl_top`

## Requirements
- R1: A sleep strobe in `ST_RUN` with `stby_sel`=0, `lowspd_sel`=1 and `tmr_mode`=1 raises `cpu_halt` on the next cycle.
- R2: A sleep strobe with any other pattern of those three bits leaves `cpu_halt` at 0 and the block in `ST_RUN`.
- R3: While asleep, `periph_clk_en` has only bit 0 (A/D converter) and bit 1 (watchdog) set. At all other times every bit is 1.
- R4: `port_hold` is 1 exactly while `cpu_halt` is 1.
- R5: While asleep, a request with `irq_req[i]`=1, `irq_en[i]`=1 and `irq_mask`=0 produces a `wake_pulse` that is high for exactly one cycle. `cpu_halt` is 0 in that cycle.
- R6: No wake occurs while `irq_mask`=1, or while no requesting source has its enable bit set.
- R7: The request passes two subclock-tick stages before the wake. With a tick every P cycles, `wake_pulse` appears between P+1 and 2P+2 cycles after the request.
- R8: `rst_n`=0 forces the running state at once: `cpu_halt`=0 and all gates are on. A reset wins over a wake request present in the same cycle, so no `wake_pulse` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed system clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous |
| sub_tick | input | 1 | One-cycle pulse per subclock period |
| sleep_op | input | 1 | Sleep instruction strobe |
| stby_sel | input | 1 | Standby-select mode bit |
| lowspd_sel | input | 1 | Low-speed-select mode bit |
| tmr_mode | input | 1 | Timer mode bit |
| irq_mask | input | 1 | Global interrupt mask |
| irq_req | input | NSRC | Interrupt requests per source |
| irq_en | input | NSRC | Enable bit per source |
| periph_clk_en | output | NGRP | Clock enable per peripheral group |
| port_hold | output | 1 | Freeze I/O port outputs |
| cpu_halt | output | 1 | Stop the CPU |
| wake_pulse | output | 1 | Start interrupt exception handling |

## Verification
The bench drives all eight mode-bit patterns with a sleep strobe. This separates the single pattern that enters sleep from the seven that must not. While asleep it applies three kinds of request:
- enabled and unmasked, which must wake;
- masked, where the wake must stay held until the mask is cleared;
- raised only on disabled sources.

Together these show whether the mask and the enable bits are applied before the synchroniser. Measuring the wake latency against the subclock tick period shows whether both synchroniser stages are present. Random rounds mix mode, mask, request and enable values. A reset asserted together with a live request checks that reset wins.

// File: rtl/sleepctl_pkg.sv
package sleepctl_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOZE   = 2'd1,
        ST_RESUME = 2'd2
    } slp_state_e;
endpackage

// File: rtl/sleepctl_wake_sync.sv
module sleepctl_wake_sync #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sub_tick,
    input  logic            arm,
    input  logic            irq_mask,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    output logic            wake_ready
);
    logic req_any;
    logic s1_q, s2_q;

    // Combined request: any enabled source, gated by the global mask
    assign req_any = ~irq_mask & (|(irq_req & irq_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else if (!arm) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else if (sub_tick) begin
            s1_q <= req_any;
            s2_q <= s1_q;
        end
    end

    assign wake_ready = s2_q;

    // R6: first stage only rises on an unmasked, enabled request
    assert_stage1_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s1_q) |-> $past(req_any));

    // R7: second stage only rises after the first stage was set
    assert_two_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s2_q) |-> $past(s1_q));
endmodule

// File: rtl/sleepctl_fsm.sv
module sleepctl_fsm
    import sleepctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_op,
    input  logic       stby_sel,
    input  logic       lowspd_sel,
    input  logic       tmr_mode,
    input  logic       wake_ready,
    output slp_state_e state
);
    slp_state_e st_q, st_d;
    logic       mode_ok;

    assign mode_ok = ~stby_sel & lowspd_sel & tmr_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:    if (sleep_op && mode_ok) st_d = ST_DOZE;
            ST_DOZE:   if (wake_ready)          st_d = ST_RESUME;
            ST_RESUME: st_d = ST_RUN;
            default:   st_d = ST_RUN;
        endcase
    end

    assign state = st_q;

    // R1: valid mode at the strobe enters sleep
    assert_enter_doze_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && sleep_op && !stby_sel && lowspd_sel && tmr_mode) |=> (st_q == ST_DOZE));

    // R2: any other mode pattern stays running
    assert_stay_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !(sleep_op && !stby_sel && lowspd_sel && tmr_mode)) |=> (st_q == ST_RUN));
endmodule

// File: rtl/sleepctl_gate.sv
module sleepctl_gate #(
    parameter int NGRP    = 6,
    parameter int ADC_IDX = 0,
    parameter int WDT_IDX = 1
) (
    input  logic            asleep,
    output logic [NGRP-1:0] clk_en
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (g == ADC_IDX || g == WDT_IDX) begin : g_keep
            assign clk_en[g] = 1'b1;
        end else begin : g_stop
            assign clk_en[g] = ~asleep;
        end
    end
endmodule

// File: rtl/sleep_ctrl_top.sv
module sleep_ctrl_top
    import sleepctl_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int NGRP    = 6,
    parameter int ADC_IDX = 0,
    parameter int WDT_IDX = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sub_tick,
    input  logic            sleep_op,
    input  logic            stby_sel,
    input  logic            lowspd_sel,
    input  logic            tmr_mode,
    input  logic            irq_mask,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    output logic [NGRP-1:0] periph_clk_en,
    output logic            port_hold,
    output logic            cpu_halt,
    output logic            wake_pulse
);
    localparam logic [NGRP-1:0] KEEP_MASK = (NGRP'(1) << ADC_IDX) | (NGRP'(1) << WDT_IDX);

    slp_state_e state;
    logic       wake_ready;
    logic       asleep;

    sleepctl_wake_sync #(.NSRC(NSRC)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sub_tick   (sub_tick),
        .arm        (asleep),
        .irq_mask   (irq_mask),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .wake_ready (wake_ready)
    );

    sleepctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_op   (sleep_op),
        .stby_sel   (stby_sel),
        .lowspd_sel (lowspd_sel),
        .tmr_mode   (tmr_mode),
        .wake_ready (wake_ready),
        .state      (state)
    );

    always_comb begin
        asleep     = 1'b0;
        wake_pulse = 1'b0;
        unique case (state)
            ST_RUN:    ;
            ST_DOZE:   asleep = 1'b1;
            ST_RESUME: wake_pulse = 1'b1;
            default:   ;
        endcase
    end

    assign cpu_halt  = asleep;
    assign port_hold = asleep;

    sleepctl_gate #(.NGRP(NGRP), .ADC_IDX(ADC_IDX), .WDT_IDX(WDT_IDX)) u_gate (
        .asleep (asleep),
        .clk_en (periph_clk_en)
    );

    // R3: only the converter and watchdog groups run while halted
    assert_gate_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> (periph_clk_en == KEEP_MASK));

    // R5: wake strobe lasts one cycle and the CPU runs during it
    assert_wake_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> (!wake_pulse && !cpu_halt));
endmodule

// File: tb/sleep_ctrl_top_tb_top.sv
module sleep_ctrl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC   = 8;
    localparam int NGRP   = 6;
    localparam int TICK_P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sub_tick = 1'b0;
    logic sleep_op = 1'b0;
    logic stby_sel = 1'b0, lowspd_sel = 1'b0, tmr_mode = 1'b0, irq_mask = 1'b0;
    logic [NSRC-1:0] irq_req = '0, irq_en = '0;
    logic [NGRP-1:0] periph_clk_en;
    logic port_hold, cpu_halt, wake_pulse;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    sleep_ctrl_top #(.NSRC(NSRC), .NGRP(NGRP)) dut_i (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .sleep_op(sleep_op),
        .stby_sel(stby_sel), .lowspd_sel(lowspd_sel), .tmr_mode(tmr_mode),
        .irq_mask(irq_mask), .irq_req(irq_req), .irq_en(irq_en),
        .periph_clk_en(periph_clk_en), .port_hold(port_hold),
        .cpu_halt(cpu_halt), .wake_pulse(wake_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit f_mode_ok(logic s, logic l, logic t);
        return !s && l && t;
    endfunction
    function automatic bit f_wake(logic m, logic [NSRC-1:0] r, logic [NSRC-1:0] e);
        return !m && (|(r & e));
    endfunction
    function automatic logic [NGRP-1:0] f_gates(bit asleep);
        return asleep ? NGRP'(6'b000011) : '1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Advance one clock; inputs are driven and outputs sampled 1 time unit after the edge
    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
        sub_tick = (cyc % TICK_P == 0);
    endtask

    task automatic check_state(bit asleep, string req);
        check(cpu_halt == asleep, req, "cpu_halt", int'(cpu_halt), int'(asleep));
        check(port_hold == asleep, "R4", "port_hold", int'(port_hold), int'(asleep));
        check(periph_clk_en == f_gates(asleep), "R3", "periph_clk_en",
              int'(periph_clk_en), int'(f_gates(asleep)));
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        #1;
        check_state(1'b0, "R8");
        check(wake_pulse == 1'b0, "R8", "wake_pulse in reset", int'(wake_pulse), 0);
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic try_sleep(logic s, logic l, logic t);
        stby_sel = s; lowspd_sel = l; tmr_mode = t;
        sleep_op = 1'b1;
        step();
        sleep_op = 1'b0;
        check_state(f_mode_ok(s, l, t), f_mode_ok(s, l, t) ? "R1" : "R2");
    endtask

    // Wait for a wake; check latency, strobe width and the absence of wakes
    task automatic wait_wake(bit exp);
        int lat = 0;
        bit got = 0;
        for (int i = 1; i <= 3*TICK_P + 4; i++) begin
            step();
            if (wake_pulse && !got) begin
                got = 1;
                lat = i;
                check(cpu_halt == 1'b0, "R5", "cpu_halt at wake", int'(cpu_halt), 0);
                step();
                check(wake_pulse == 1'b0, "R5", "wake width", int'(wake_pulse), 0);
                check_state(1'b0, "R5");
                break;
            end
        end
        check(got == exp, exp ? "R5" : "R6", "wake seen", int'(got), int'(exp));
        if (exp && got)
            check(lat >= TICK_P + 1 && lat <= 2*TICK_P + 2, "R7", "wake latency",
                  lat, 2*TICK_P + 1);
        if (!exp)
            check(cpu_halt == 1'b1, "R6", "still halted", int'(cpu_halt), 1);
        irq_req = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout actual=%0d expected=finish", cyc);
        summary();
    end

    initial begin
        void'($urandom(1234));
        #1;
        check_state(1'b0, "R8");
        check(wake_pulse == 1'b0, "R8", "wake after reset", int'(wake_pulse), 0);
        step(); step();
        rst_n = 1'b1;
        step();

        // R1/R2: all eight patterns of the mode bits
        for (int m = 0; m < 8; m++) begin
            try_sleep(m[2], m[1], m[0]);
            if (cpu_halt) begin
                irq_mask = 1'b0; irq_en = 8'h01; irq_req = 8'h01;
                wait_wake(1'b1);
            end
            step();
        end

        // R6: masked request holds sleep, then unmasking wakes
        try_sleep(1'b0, 1'b1, 1'b1);
        irq_mask = 1'b1; irq_en = 8'hFF; irq_req = 8'hFF;
        wait_wake(1'b0);
        irq_req = 8'hFF; irq_mask = 1'b0;
        wait_wake(1'b1);

        // R6: requests only on disabled sources, then R8 reset from sleep
        step();
        try_sleep(1'b0, 1'b1, 1'b1);
        irq_en = 8'hF0; irq_req = 8'h0F;
        wait_wake(1'b0);
        pulse_reset();

        // R8: reset together with a live enabled request
        try_sleep(1'b0, 1'b1, 1'b1);
        irq_en = 8'h80; irq_req = 8'h80;
        for (int i = 0; i < 2*TICK_P - 1; i++) step();
        rst_n = 1'b0;
        #1;
        check_state(1'b0, "R8");
        step();
        irq_req = '0;
        rst_n = 1'b1;
        for (int i = 0; i < 3*TICK_P; i++) begin
            step();
            check(wake_pulse == 1'b0, "R8", "no wake after reset", int'(wake_pulse), 0);
        end

        // Random rounds
        for (int r = 0; r < 60; r++) begin
            logic [2:0] mb;
            logic [NSRC-1:0] rq, en;
            logic mk;
            mb = 3'($urandom());
            if ($urandom() % 2 == 0) mb = 3'b011;
            try_sleep(mb[2], mb[1], mb[0]);
            if (cpu_halt) begin
                rq = NSRC'($urandom()); en = NSRC'($urandom());
                mk = ($urandom() % 4 == 0);
                irq_mask = mk; irq_req = rq; irq_en = en;
                wait_wake(f_wake(mk, rq, en));
                if (cpu_halt) pulse_reset();
            end
            irq_mask = 1'b0;
            step();
        end
        summary();
    end
endmodule